// File: doc/BRIEF.md
# Split-Word 64-bit Register Access Bridge

This bridge gives a host that only has a 32-bit register port full read and write access to the 64-bit registers of an attached engine. The host places the upper and lower halves of a 64-bit value in two 32-bit staging registers. It then writes a command word. Bit 31 of that word selects the direction, and the remaining bits carry the downstream register address. That command write is the only trigger for an access. A write sends the staged value downstream. A read loads the engine's 64-bit answer back into the two staging registers, where the host then collects it.

The bridge is busy from the trigger until the engine answers, and a status register shows this. Several conditions raise a sticky any-error flag in the status register:

- a command written while the bridge is busy
- a command whose address falls outside the engine's register window
- an error response from the engine
- no response within a bounded number of cycles

Writing any value to the reset register clears the flag and abandons an outstanding request. An interrupt-enable register gates the error flag onto an interrupt output.

Top module: `split64_bridge`

## Requirements
- R1: After reset both staging registers, the status register and the interrupt-enable register read 0, `irq` is low and `req_valid` is low.
- R2: The host can write and read back both staging registers: offset 0x00 holds bits 63:32 of the 64-bit value and offset 0x04 holds bits 31:0.
- R3: Writing offset 0x08 with bit 31 set and an address 0x70000+i (i < 16) issues exactly one downstream write with `req_write`=1, `req_index`=i and `req_wdata` equal to the staged value. `req_valid` holds stable until `req_ready`.
- R4: The same command with bit 31 clear issues a downstream read. A successful response then appears as bits 63:32 at offset 0x00 and bits 31:0 at offset 0x04.
- R5: Status bit 0 (busy) reads 1 from the cycle after an accepted command until the response arrives. Busy rises only after a command write.
- R6: A command written while busy is not issued and sets the error flag (status bit 31). The access already in flight is unaffected.
- R7: A command whose address bits 30:4 differ from those of 0x70000 sets the error flag, issues no request and does not make the bridge busy.
- R8: An error response (`rsp_err`=1) ends the access, sets the error flag and leaves both staging registers unchanged.
- R9: If no response arrives within 256 cycles of the trigger, the access ends, busy drops, the error flag is set and the staging registers are unchanged.
- R10: The error flag stays set through later successful accesses until any value is written to offset 0x18, which clears it.
- R11: A write to offset 0x18 during an access abandons it: busy and `req_valid` drop, and the late response is ignored.
- R12: Offset 0x20 bit 0 is an interrupt enable. `irq` equals that enable ANDed with the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one register per cycle |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| irq | output | 1 | Error interrupt |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_index | output | 4 | Engine register index |
| req_wdata | output | 64 | Write value, latched at the trigger |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_err | input | 1 | Response carries an error |
| rsp_rdata | input | 64 | Read result |

## Verification
The assertions take three things for granted about the inputs:

- The engine answers only after it has accepted a request.
- The engine gives at most one response per request.
- The host does not rewrite a staging register in the same cycle as a read result lands.

The bench's engine model raises `req_ready` only while `req_valid` is high and answers once after a random latency. It can be switched to stay silent or to answer with an error. The host tasks poll busy before touching the staging registers again. The one exception is the directed timeout and abort cases, where the silent engine guarantees that no result can land.

// File: rtl/split64_pkg.sv
package split64_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HADDR_W = 8;
  localparam int HALF_W  = 32;
  localparam int WORD_W  = 2 * HALF_W;

  localparam logic [HADDR_W-1:0] OFS_DATA_HI = 8'h00;
  localparam logic [HADDR_W-1:0] OFS_DATA_LO = 8'h04;
  localparam logic [HADDR_W-1:0] OFS_CMD     = 8'h08;
  localparam logic [HADDR_W-1:0] OFS_CLEAR   = 8'h18;
  localparam logic [HADDR_W-1:0] OFS_STATUS  = 8'h1C;
  localparam logic [HADDR_W-1:0] OFS_IRQ     = 8'h20;

  localparam int STS_ERR_BIT  = 31;
  localparam int STS_BUSY_BIT = 0;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic        write;
    logic [30:0] addr;
  } cmd_word_t;
endpackage

// File: rtl/split64_rstsync.sv
module split64_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 100ps;

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/split64_hostregs.sv
module split64_hostregs
  import split64_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HALF_W-1:0]  host_wdata,
  input  logic               load_valid,
  input  logic [WORD_W-1:0]  load_data,
  input  logic               busy,
  input  logic               err_q,
  output logic [WORD_W-1:0]  data_q,
  output logic               cmd_strobe,
  output logic               clear_strobe,
  output logic               irq_en_q,
  output logic [HALF_W-1:0]  host_rdata
);
  timeunit 1ns;
  timeprecision 100ps;

  logic              hi_we;
  logic              lo_we;
  logic              irq_we;
  logic              data_en;
  logic [WORD_W-1:0] data_d;

  // write decode
  always_comb begin
    hi_we        = host_wr && (host_addr == OFS_DATA_HI);
    lo_we        = host_wr && (host_addr == OFS_DATA_LO);
    irq_we       = host_wr && (host_addr == OFS_IRQ);
    cmd_strobe   = host_wr && (host_addr == OFS_CMD);
    clear_strobe = host_wr && (host_addr == OFS_CLEAR);
  end

  // staging next value: a returning read result takes the whole word
  always_comb begin
    data_d  = data_q;
    data_en = load_valid || hi_we || lo_we;
    if (load_valid) begin
      data_d = load_data;
    end else begin
      if (hi_we) data_d[WORD_W-1:HALF_W] = host_wdata;
      if (lo_we) data_d[HALF_W-1:0]      = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
    end else if (irq_we) begin
      irq_en_q <= host_wdata[0];
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_DATA_HI: host_rdata = data_q[WORD_W-1:HALF_W];
      OFS_DATA_LO: host_rdata = data_q[HALF_W-1:0];
      OFS_STATUS: begin
        host_rdata[STS_ERR_BIT]  = err_q;
        host_rdata[STS_BUSY_BIT] = busy;
      end
      OFS_IRQ:     host_rdata[0] = irq_en_q;
      default:     host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/split64_errflag.sv
module split64_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  input  logic err_clear,
  output logic err_q
);
  timeunit 1ns;
  timeprecision 100ps;

  logic err_d;
  logic err_en;

  always_comb begin
    err_en = err_set || err_clear;
    err_d  = !err_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/split64_xfer.sv
module split64_xfer
  import split64_pkg::*;
#(
  parameter logic [30:0] ENGINE_BASE = 31'h0007_0000,
  parameter int          IDX_W       = 4,
  parameter int          TIMEOUT_CYC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_strobe,
  input  logic [HALF_W-1:0]  cmd_word,
  input  logic               clear_strobe,
  input  logic [WORD_W-1:0]  data_q,
  input  logic               req_ready,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic [WORD_W-1:0]  rsp_rdata,
  output logic               req_valid,
  output logic               req_write,
  output logic [IDX_W-1:0]   req_index,
  output logic [WORD_W-1:0]  req_wdata,
  output logic               load_valid,
  output logic [WORD_W-1:0]  load_data,
  output logic               busy,
  output logic               err_set
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int                TAG_W   = 31 - IDX_W;
  localparam logic [TAG_W-1:0]  WIN_TAG = TAG_W'(ENGINE_BASE >> IDX_W);
  localparam int                CNT_W   = $clog2(TIMEOUT_CYC + 2);
  localparam logic [CNT_W-1:0]  CNT_END = CNT_W'(TIMEOUT_CYC - 1);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              op_en;
  logic              op_write_q;
  logic [IDX_W-1:0]  op_index_q;
  logic [WORD_W-1:0] op_wdata_q;
  cmd_word_t         cmd;
  logic              in_window;
  logic              accept;
  logic              expired;
  logic              fail;

  always_comb begin
    cmd       = cmd_word_t'(cmd_word);
    in_window = (cmd.addr[30:IDX_W] == WIN_TAG);
    accept    = cmd_strobe && (state_q == XS_IDLE) && in_window;
    expired   = (cnt_q >= CNT_END);
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    op_en      = 1'b0;
    load_valid = 1'b0;
    fail       = 1'b0;
    case (state_q)
      XS_IDLE: begin
        if (accept) begin
          state_d = XS_ISSUE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          op_en   = 1'b1;
        end
      end
      XS_ISSUE: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (req_ready) begin
          state_d = XS_WAIT;
        end else if (expired) begin
          state_d = XS_IDLE;
          fail    = 1'b1;
        end
      end
      XS_WAIT: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (rsp_valid) begin
          state_d    = XS_IDLE;
          fail       = rsp_err;
          load_valid = !rsp_err && !op_write_q;
        end else if (expired) begin
          state_d = XS_IDLE;
          fail    = 1'b1;
        end
      end
      default: state_d = XS_IDLE;
    endcase
    if (clear_strobe) begin
      state_d    = XS_IDLE;
      fail       = 1'b0;
      load_valid = 1'b0;
    end
  end

  always_comb begin
    err_set = (fail || (cmd_strobe && !accept)) && !clear_strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write_q <= 1'b0;
      op_index_q <= '0;
      op_wdata_q <= '0;
    end else if (op_en) begin
      op_write_q <= cmd.write;
      op_index_q <= cmd.addr[IDX_W-1:0];
      op_wdata_q <= data_q;
    end
  end

  always_comb begin
    busy      = (state_q != XS_IDLE);
    req_valid = (state_q == XS_ISSUE);
    req_write = op_write_q;
    req_index = op_index_q;
    req_wdata = op_wdata_q;
    load_data = rsp_rdata;
  end
endmodule

// File: rtl/split64_bridge.sv
module split64_bridge
  import split64_pkg::*;
#(
  parameter logic [30:0] ENGINE_BASE = 31'h0007_0000,
  parameter int          IDX_W       = 4,
  parameter int          TIMEOUT_CYC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HALF_W-1:0]  host_wdata,
  output logic [HALF_W-1:0]  host_rdata,
  output logic               irq,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [IDX_W-1:0]   req_index,
  output logic [WORD_W-1:0]  req_wdata,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic [WORD_W-1:0]  rsp_rdata
);
  timeunit 1ns;
  timeprecision 100ps;

  logic              rst_sync_n;
  logic [WORD_W-1:0] data_q;
  logic              cmd_strobe;
  logic              clear_strobe;
  logic              irq_en_q;
  logic              load_valid;
  logic [WORD_W-1:0] load_data;
  logic              busy;
  logic              err_set;
  logic              err_q;

  split64_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  split64_hostregs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .load_valid   (load_valid),
    .load_data    (load_data),
    .busy         (busy),
    .err_q        (err_q),
    .data_q       (data_q),
    .cmd_strobe   (cmd_strobe),
    .clear_strobe (clear_strobe),
    .irq_en_q     (irq_en_q),
    .host_rdata   (host_rdata)
  );

  split64_xfer #(
    .ENGINE_BASE (ENGINE_BASE),
    .IDX_W       (IDX_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_xfer (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_strobe   (cmd_strobe),
    .cmd_word     (host_wdata),
    .clear_strobe (clear_strobe),
    .data_q       (data_q),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_index    (req_index),
    .req_wdata    (req_wdata),
    .load_valid   (load_valid),
    .load_data    (load_data),
    .busy         (busy),
    .err_set      (err_set)
  );

  split64_errflag u_err (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .err_set   (err_set),
    .err_clear (clear_strobe),
    .err_q     (err_q)
  );

  assign irq = irq_en_q && err_q;
endmodule

// File: rtl/split64_checker.sv
module split64_checker #(
  parameter int IDX_W       = 4,
  parameter int TIMEOUT_CYC = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err_q,
  input logic [63:0]       data_q,
  input logic              load_valid,
  input logic              host_wr,
  input logic              cmd_strobe,
  input logic              clear_strobe,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IDX_W-1:0]  req_index,
  input logic [63:0]       req_wdata
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RUN_W = $clog2(TIMEOUT_CYC + 4) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !clear_strobe) |=>
      (!req_valid || ($stable(req_index) && $stable(req_wdata))));

  assert_busy_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_strobe));

  assert_cmd_busy_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_strobe) |=> err_q);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !load_valid) |=> $stable(data_q));

  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q <= RUN_W'(TIMEOUT_CYC + 1)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_strobe) |=> err_q);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_strobe |=> !err_q);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_strobe |=> (!busy && !req_valid));
endmodule

bind split64_bridge split64_checker #(
  .IDX_W       (IDX_W),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .busy         (busy),
  .err_q        (err_q),
  .data_q       (data_q),
  .load_valid   (load_valid),
  .host_wr      (host_wr),
  .cmd_strobe   (cmd_strobe),
  .clear_strobe (clear_strobe),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_index    (req_index),
  .req_wdata    (req_wdata)
);

// File: tb/test_split64_bridge.sv
module test_split64_bridge;
  timeunit 1ns;
  timeprecision 100ps;
  import split64_pkg::*;

  localparam int          IDX_W = 4;
  localparam int          NREG  = 16;
  localparam logic [30:0] BASE  = 31'h0007_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_wr;
  logic [7:0]        host_addr;
  logic [31:0]       host_wdata;
  logic [31:0]       host_rdata;
  logic              irq;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [IDX_W-1:0]  req_index;
  logic [63:0]       req_wdata;
  logic              rsp_valid;
  logic              rsp_err;
  logic [63:0]       rsp_rdata;

  always #2.5 clk = ~clk;

  split64_bridge i_split64_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq        (irq),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_index  (req_index),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [63:0] eng_mem [NREG];
  logic [63:0] model   [NREG];
  bit          eng_mute = 1'b0;
  bit          eng_err  = 1'b0;
  int          hs_count = 0;
  bit          op_w;
  logic [IDX_W-1:0] op_idx;
  logic [63:0] op_wd;
  bit          pend;
  int          lat;

  function automatic logic [63:0] seed_word(int i);
    return {32'hC0DE_0000 | 32'(i), 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101)};
  endfunction

  function automatic logic [31:0] cmd_of(bit w, int idx);
    return {w, BASE + 31'(idx)};
  endfunction

  // engine model: decisions at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
      pend = 1'b0; lat = 0;
    end else begin
      rsp_valid = 1'b0;
      rsp_err   = 1'b0;
      if (req_ready) begin
        req_ready = 1'b0;
        hs_count++;
        pend = 1'b1;
        lat  = 1 + int'($urandom % 4);
        if (op_w && !eng_err) eng_mem[op_idx] = op_wd;
      end else if (pend) begin
        lat--;
        if (lat == 0) begin
          pend = 1'b0;
          if (!eng_mute) begin
            rsp_valid = 1'b1;
            rsp_err   = eng_err;
            rsp_rdata = eng_err ? 64'hBAD0_BAD0_BAD0_BAD0 : eng_mem[op_idx];
          end
        end
      end else if (req_valid && ($urandom % 3) != 0) begin
        req_ready = 1'b1;
        op_w   = req_write;
        op_idx = req_index;
        op_wd  = req_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic hr64(output logic [63:0] v);
    logic [31:0] hi, lo;
    hr(OFS_DATA_HI, hi);
    hr(OFS_DATA_LO, lo);
    v = {hi, lo};
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit idle = 1'b0;
    for (int k = 0; k < 600; k++) begin
      hr(OFS_STATUS, s);
      if (!s[0]) begin idle = 1'b1; break; end
      @(negedge clk);
    end
    if (!idle) chk(req, 64'd1, 64'd0);
  endtask

  task automatic stage(input logic [63:0] v);
    hw(OFS_DATA_HI, v[63:32]);
    hw(OFS_DATA_LO, v[31:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [63:0] v, staged;
    int h0;
    for (int i = 0; i < NREG; i++) begin
      eng_mem[i] = seed_word(i);
      model[i]   = seed_word(i);
    end
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hr64(v);           chk("R1 data", v, 64'd0);
    hr(OFS_STATUS, s); chk("R1 status", 64'(s), 64'd0);
    hr(OFS_IRQ, s);    chk("R1 irq enable", 64'(s), 64'd0);
    chk("R1 irq pin", 64'(irq), 64'd0);
    chk("R1 req_valid", 64'(req_valid), 64'd0);

    // R2 staging readback
    hw(OFS_DATA_HI, 32'h1234_5678);
    hw(OFS_DATA_LO, 32'h9ABC_DEF0);
    hr(OFS_DATA_HI, s); chk("R2 upper half", 64'(s), 64'h1234_5678);
    hr(OFS_DATA_LO, s); chk("R2 lower half", 64'(s), 64'h9ABC_DEF0);

    // R3 directed write to the top index, R5 busy right after trigger
    stage(64'hFEED_FACE_0BAD_F00D);
    hw(OFS_CMD, cmd_of(1'b1, 15));
    hr(OFS_STATUS, s); chk("R5 busy after trigger", 64'(s[0]), 64'd1);
    wait_idle("R3 completion");
    hr(OFS_STATUS, s); chk("R3 no error", 64'(s[31]), 64'd0);
    chk("R3 engine got value", eng_mem[15], 64'hFEED_FACE_0BAD_F00D);
    model[15] = 64'hFEED_FACE_0BAD_F00D;

    // R4 directed read of index 0
    hw(OFS_CMD, cmd_of(1'b0, 0));
    wait_idle("R4 completion");
    hr64(v); chk("R4 read index 0", v, seed_word(0));

    // R6 command while busy (silent engine keeps it busy)
    eng_mute = 1'b1;
    h0 = hs_count;
    hw(OFS_CMD, cmd_of(1'b0, 3));
    hw(OFS_CMD, cmd_of(1'b0, 4));
    hr(OFS_STATUS, s); chk("R6 error on busy cmd", 64'(s[31]), 64'd1);
    chk("R6 first access still busy", 64'(s[0]), 64'd1);
    repeat (12) @(negedge clk);
    chk("R6 one request only", 64'(hs_count - h0), 64'd1);

    // R11 abort and R10 clear
    hw(OFS_CLEAR, 32'h0);
    hr(OFS_STATUS, s); chk("R11 R10 status after clear", 64'(s), 64'd0);
    chk("R11 req_valid dropped", 64'(req_valid), 64'd0);

    // R9 timeout
    staged = 64'h0102_0304_0506_0708;
    stage(staged);
    hw(OFS_CMD, cmd_of(1'b0, 5));
    repeat (250) @(negedge clk);
    hr(OFS_STATUS, s); chk("R9 still busy before limit", 64'(s), 64'd1);
    repeat (10) @(negedge clk);
    hr(OFS_STATUS, s); chk("R9 timed out", 64'(s), 64'h8000_0000);
    hr64(v); chk("R9 data unchanged", v, staged);
    hw(OFS_CLEAR, 32'h0);
    eng_mute = 1'b0;

    // R8 error response
    eng_err = 1'b1;
    staged = 64'hAAAA_5555_CCCC_3333;
    stage(staged);
    hw(OFS_CMD, cmd_of(1'b0, 6));
    wait_idle("R8 completion");
    hr(OFS_STATUS, s); chk("R8 error flag", 64'(s[31]), 64'd1);
    hr64(v); chk("R8 data unchanged", v, staged);
    eng_err = 1'b0;
    hw(OFS_CLEAR, 32'h0);

    // R7 address window
    h0 = hs_count;
    hw(OFS_CMD, 32'h0001_0002);
    hr(OFS_STATUS, s); chk("R7 reject far address", 64'(s), 64'h8000_0000);
    hw(OFS_CLEAR, 32'h0);
    hw(OFS_CMD, cmd_of(1'b1, 16));
    hr(OFS_STATUS, s); chk("R7 reject just above window", 64'(s), 64'h8000_0000);
    repeat (8) @(negedge clk);
    chk("R7 no request issued", 64'(hs_count - h0), 64'd0);
    hw(OFS_CLEAR, 32'h0);

    // R12 interrupt gating, R10 stickiness through a good access
    hw(OFS_IRQ, 32'h1);
    hr(OFS_IRQ, s); chk("R12 enable readback", 64'(s), 64'd1);
    chk("R12 irq low without error", 64'(irq), 64'd0);
    hw(OFS_CMD, 32'h0000_0000);
    chk("R12 irq on error", 64'(irq), 64'd1);
    hw(OFS_CMD, cmd_of(1'b0, 1));
    wait_idle("R10 completion");
    hr(OFS_STATUS, s); chk("R10 flag sticky", 64'(s[31]), 64'd1);
    hr64(v); chk("R4 read index 1", v, seed_word(1));
    hw(OFS_IRQ, 32'h0);
    chk("R12 irq masked", 64'(irq), 64'd0);
    hw(OFS_IRQ, 32'h1);
    hw(OFS_CLEAR, 32'hFFFF_FFFF);
    chk("R12 irq after clear", 64'(irq), 64'd0);
    hr(OFS_STATUS, s); chk("R10 cleared", 64'(s), 64'd0);

    // random mix of writes and reads
    for (int n = 0; n < 60; n++) begin
      int idx;
      logic [63:0] d;
      idx = int'($urandom % NREG);
      if (($urandom % 2) == 0) begin
        d = {$urandom, $urandom};
        stage(d);
        hw(OFS_CMD, cmd_of(1'b1, idx));
        wait_idle("R3 random completion");
        chk("R3 random write", eng_mem[idx], d);
        model[idx] = d;
      end else begin
        hw(OFS_CMD, cmd_of(1'b0, idx));
        wait_idle("R4 random completion");
        hr64(v); chk("R4 random read", v, model[idx]);
      end
      hr(OFS_STATUS, s); chk("R10 no spurious error", 64'(s[31]), 64'd0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule